// File: doc/BRIEF.md
# Control-Path Signature Abort Detector

The block follows the path that the primary thread's front end fetches. For each taken control-flow instruction it records a short partial address and a confidence bit in a history shift register. Up to a parameterised number of helper microthreads can be active at once. Each active microthread holds the path it assumes the primary thread will take, written as a list of expected partial addresses with a per-element compare enable.

On every taken branch, each entry's expected list moves forward one position together with the history. The element that lines up with a history position is compared with it. When a compared element differs, and that history position and every older compared position are marked confident, the block raises a one-cycle abort for that entry and retires the entry.

A misprediction recovery shifts the history and every entry back by the number of branches to discard. Expected elements that were already consumed return to their pending state, so comparison resumes as if the discarded branches had never been fetched. The front end issues spawns, frees and recoveries; the abort pulses go to the queue-flush logic.

Top module: `sig_abort_detector`

## Requirements
- R1: After reset, abort_o is all zero, no entry is active, and the history holds no branches.
- R2: A spawn writes an expected path into the addressed slot and makes the slot active. Element j sits at bits [4j+3:4j] of spawn_vec_i and is compared only when bit j of spawn_mask_i is 1. Element j is compared with the (j+1)-th taken branch recorded after the spawn. A branch given in the same cycle as the spawn counts as the first one. A spawn into an active slot replaces its contents.
- R3: When an active entry's compared element differs from the partial address (4 bits) of the matching branch, abort_o for that slot is 1 for exactly the cycle after the clock edge that recorded the branch. Matching branches raise nothing.
- R4: An element whose mask bit is 0 never causes an abort, whatever branch address lines up with it.
- R5: An abort is raised only if the mismatching branch and every older compared branch since the spawn carry confidence 1. Otherwise the abort is suppressed.
- R6: A recovery with count n (values above the history depth act as the depth) discards the n newest branches. It shifts every entry back to match, including elements consumed after the spawn. Following branches are compared as if the discarded ones never happened. A recovery by itself raises no abort.
- R7: In a cycle with a recovery, a branch event is ignored. An entry spawned in that cycle is written without being shifted back.
- R8: A freed slot becomes inactive and raises no abort until it is spawned again.
- R9: An entry that has aborted becomes inactive and produces no further abort pulse.
- R10: Slots are independent. Several slots can abort in the same cycle, and each abort affects only its own slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_valid_i | input | 1 | A taken control-flow instruction is fetched this cycle |
| br_addr_i | input | PA_W (4) | Partial address bits of that instruction |
| br_conf_i | input | 1 | Confidence that the branch lies on the correct path |
| rec_valid_i | input | 1 | Misprediction recovery this cycle |
| rec_count_i | input | CNT_W (4) | Number of newest branches to discard |
| spawn_valid_i | input | 1 | A microthread is spawned this cycle |
| spawn_slot_i | input | SLOT_W (4) | Slot to write |
| spawn_vec_i | input | EXP_LEN*PA_W (32) | Expected path; element 0 is in the low bits |
| spawn_mask_i | input | EXP_LEN (8) | Compare enable for each element |
| free_valid_i | input | 1 | A microthread has completed |
| free_slot_i | input | SLOT_W (4) | Slot to free |
| abort_o | output | NUM_SLOTS (16) | One-cycle abort pulse for each slot |

## Verification
The bench builds the block with its default parameters: 16 slots, a history depth of 8, 8 expected elements and 4-bit partial addresses. It drives slots 0 and 15 so that both ends of the slot decode are covered. The paths it uses are at most three branches long, well inside the depth. This leaves room for recoveries that reach back past the spawn point, returning a consumed element to pending, and for branches recorded ahead of the first compared element.

// File: rtl/sig_abort_pkg.sv
package sig_abort_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_PUSH   = 2'd1,
    OP_UNWIND = 2'd2
  } shift_op_e;
endpackage

// File: rtl/sig_history.sv
module sig_history
  import sig_abort_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PA_W  = 4,
  parameter int unsigned CNT_W = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  shift_op_e                   op_i,
  input  logic [PA_W-1:0]             addr_i,
  input  logic                        conf_i,
  input  logic [CNT_W-1:0]            unwind_i,
  output logic [DEPTH-1:0][PA_W-1:0]  addr_o,
  output logic [DEPTH-1:0]            conf_o
);
  logic [DEPTH-1:0][PA_W-1:0] addr_q, addr_d;
  logic [DEPTH-1:0]           conf_q, conf_d;

  // slot 0 holds the newest branch
  always_comb begin
    addr_d = addr_q;
    conf_d = conf_q;
    case (op_i)
      OP_PUSH: begin
        addr_d = {addr_q[DEPTH-2:0], addr_i};
        conf_d = {conf_q[DEPTH-2:0], conf_i};
      end
      OP_UNWIND: begin
        addr_d = addr_q >> (PA_W * unwind_i);
        conf_d = conf_q >> unwind_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      conf_q <= '0;
    end else begin
      addr_q <= addr_d;
      conf_q <= conf_d;
    end
  end

  assign addr_o = addr_q;
  assign conf_o = conf_q;
endmodule

// File: rtl/sig_slot.sv
module sig_slot
  import sig_abort_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned EXP_LEN = 8,
  parameter int unsigned PA_W    = 4,
  parameter int unsigned CNT_W   = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  shift_op_e                     op_i,
  input  logic [CNT_W-1:0]              unwind_i,
  input  logic                          load_i,
  input  logic [EXP_LEN-1:0][PA_W-1:0]  load_vec_i,
  input  logic [EXP_LEN-1:0]            load_mask_i,
  input  logic                          clear_i,
  output logic                          valid_o,
  output logic [DEPTH-1:0][PA_W-1:0]    al_addr_o,
  output logic [DEPTH-1:0]              al_mask_o
);
  localparam int unsigned TOT = DEPTH + EXP_LEN;

  // index < EXP_LEN: pending (EXP_LEN-1 is next expected); index >= EXP_LEN: aligned with history
  logic [TOT-1:0][PA_W-1:0] s_addr_q, s_addr_d, base_addr;
  logic [TOT-1:0]           s_mask_q, s_mask_d, base_mask;
  logic                     valid_q;

  always_comb begin
    base_addr = s_addr_q;
    base_mask = s_mask_q;
    if (load_i) begin
      base_addr = '0;
      base_mask = '0;
      for (int j = 0; j < EXP_LEN; j++) begin
        base_addr[EXP_LEN-1-j] = load_vec_i[j];
        base_mask[EXP_LEN-1-j] = load_mask_i[j];
      end
    end
  end

  always_comb begin
    s_addr_d = base_addr;
    s_mask_d = base_mask;
    if (op_i == OP_PUSH) begin
      s_addr_d = {base_addr[TOT-2:0], {PA_W{1'b0}}};
      s_mask_d = {base_mask[TOT-2:0], 1'b0};
    end else if (op_i == OP_UNWIND && !load_i) begin
      s_addr_d = base_addr >> (PA_W * unwind_i);
      s_mask_d = base_mask >> unwind_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_addr_q <= '0;
      s_mask_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      s_addr_q <= s_addr_d;
      s_mask_q <= s_mask_d;
      if (load_i)       valid_q <= 1'b1;
      else if (clear_i) valid_q <= 1'b0;
    end
  end

  assign valid_o   = valid_q;
  assign al_addr_o = s_addr_q[TOT-1:EXP_LEN];
  assign al_mask_o = s_mask_q[TOT-1:EXP_LEN];
endmodule

// File: rtl/sig_match.sv
module sig_match #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PA_W  = 4
) (
  input  logic                        valid_i,
  input  logic [DEPTH-1:0][PA_W-1:0]  hist_addr_i,
  input  logic [DEPTH-1:0]            hist_conf_i,
  input  logic [DEPTH-1:0][PA_W-1:0]  al_addr_i,
  input  logic [DEPTH-1:0]            al_mask_i,
  output logic                        abort_o
);
  logic hit;
  logic all_conf;

  // walk oldest to newest; a mismatch counts only if it and all older compared slots are confident
  always_comb begin
    hit      = 1'b0;
    all_conf = 1'b1;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (al_mask_i[k]) begin
        all_conf = all_conf & hist_conf_i[k];
        if (all_conf && (al_addr_i[k] != hist_addr_i[k])) hit = 1'b1;
      end
    end
  end

  assign abort_o = valid_i & hit;
endmodule

// File: rtl/sig_abort_detector.sv
module sig_abort_detector
  import sig_abort_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 16,
  parameter int unsigned PA_W       = 4,
  parameter int unsigned HIST_DEPTH = 8,
  parameter int unsigned EXP_LEN    = 8,
  localparam int unsigned SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int unsigned CNT_W     = $clog2(HIST_DEPTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      br_valid_i,
  input  logic [PA_W-1:0]           br_addr_i,
  input  logic                      br_conf_i,
  input  logic                      rec_valid_i,
  input  logic [CNT_W-1:0]          rec_count_i,
  input  logic                      spawn_valid_i,
  input  logic [SLOT_W-1:0]         spawn_slot_i,
  input  logic [EXP_LEN*PA_W-1:0]   spawn_vec_i,
  input  logic [EXP_LEN-1:0]        spawn_mask_i,
  input  logic                      free_valid_i,
  input  logic [SLOT_W-1:0]         free_slot_i,
  output logic [NUM_SLOTS-1:0]      abort_o
);
  shift_op_e                       op;
  logic [CNT_W-1:0]                unwind_n;
  logic [HIST_DEPTH-1:0][PA_W-1:0] hist_addr;
  logic [HIST_DEPTH-1:0]           hist_conf;
  logic [EXP_LEN-1:0][PA_W-1:0]    vec_w;
  logic [NUM_SLOTS-1:0]            abort_w;

  // recovery wins: the branch event of that cycle lies on the discarded path
  assign op       = rec_valid_i ? OP_UNWIND : (br_valid_i ? OP_PUSH : OP_IDLE);
  assign unwind_n = (rec_count_i > CNT_W'(HIST_DEPTH)) ? CNT_W'(HIST_DEPTH) : rec_count_i;
  assign vec_w    = spawn_vec_i;

  sig_history #(
    .DEPTH (HIST_DEPTH),
    .PA_W  (PA_W),
    .CNT_W (CNT_W)
  ) u_hist (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .addr_i   (br_addr_i),
    .conf_i   (br_conf_i),
    .unwind_i (unwind_n),
    .addr_o   (hist_addr),
    .conf_o   (hist_conf)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic                            load_s, clear_s, valid_s;
    logic [HIST_DEPTH-1:0][PA_W-1:0] al_addr_s;
    logic [HIST_DEPTH-1:0]           al_mask_s;

    assign load_s  = spawn_valid_i && (spawn_slot_i == SLOT_W'(s));
    assign clear_s = abort_w[s] || (free_valid_i && (free_slot_i == SLOT_W'(s)));

    sig_slot #(
      .DEPTH   (HIST_DEPTH),
      .EXP_LEN (EXP_LEN),
      .PA_W    (PA_W),
      .CNT_W   (CNT_W)
    ) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .op_i        (op),
      .unwind_i    (unwind_n),
      .load_i      (load_s),
      .load_vec_i  (vec_w),
      .load_mask_i (spawn_mask_i),
      .clear_i     (clear_s),
      .valid_o     (valid_s),
      .al_addr_o   (al_addr_s),
      .al_mask_o   (al_mask_s)
    );

    sig_match #(
      .DEPTH (HIST_DEPTH),
      .PA_W  (PA_W)
    ) u_match (
      .valid_i     (valid_s),
      .hist_addr_i (hist_addr),
      .hist_conf_i (hist_conf),
      .al_addr_i   (al_addr_s),
      .al_mask_i   (al_mask_s),
      .abort_o     (abort_w[s])
    );
  end

  assign abort_o = abort_w;
endmodule

// File: rtl/sig_abort_checker.sv
module sig_abort_checker #(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned SLOT_W    = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 br_valid_i,
  input logic                 rec_valid_i,
  input logic                 spawn_valid_i,
  input logic [SLOT_W-1:0]    spawn_slot_i,
  input logic                 free_valid_i,
  input logic [SLOT_W-1:0]    free_slot_i,
  input logic [NUM_SLOTS-1:0] abort_o
);
  // R6: recovery alone never creates an abort
  p_unwind_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_i) |=> (abort_o == '0));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
    logic spawn_here;
    assign spawn_here = spawn_valid_i && (spawn_slot_i == SLOT_W'(s));

    // R9: one-cycle pulse, entry retired
    p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (abort_o[s] && !spawn_here) |=> !abort_o[s]);

    // R8: freed slot stays quiet
    p_freed_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (free_valid_i && (free_slot_i == SLOT_W'(s)) && !spawn_here) |=> !abort_o[s]);

    // R3: a new abort follows a recorded branch
    p_abort_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(abort_o[s]) |-> $past(br_valid_i && !rec_valid_i));
  end
endmodule

bind sig_abort_detector sig_abort_checker #(
  .NUM_SLOTS (NUM_SLOTS),
  .SLOT_W    (SLOT_W)
) u_sig_abort_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .br_valid_i    (br_valid_i),
  .rec_valid_i   (rec_valid_i),
  .spawn_valid_i (spawn_valid_i),
  .spawn_slot_i  (spawn_slot_i),
  .free_valid_i  (free_valid_i),
  .free_slot_i   (free_slot_i),
  .abort_o       (abort_o)
);

// File: tb/sig_abort_detector_tb_top.sv
module sig_abort_detector_tb_top;
  localparam int NS = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        br_valid_i = 1'b0;
  logic [3:0]  br_addr_i = '0;
  logic        br_conf_i = 1'b0;
  logic        rec_valid_i = 1'b0;
  logic [3:0]  rec_count_i = '0;
  logic        spawn_valid_i = 1'b0;
  logic [3:0]  spawn_slot_i = '0;
  logic [31:0] spawn_vec_i = '0;
  logic [7:0]  spawn_mask_i = '0;
  logic        free_valid_i = 1'b0;
  logic [3:0]  free_slot_i = '0;
  logic [NS-1:0] abort_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  sig_abort_detector dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .br_valid_i(br_valid_i), .br_addr_i(br_addr_i), .br_conf_i(br_conf_i),
    .rec_valid_i(rec_valid_i), .rec_count_i(rec_count_i),
    .spawn_valid_i(spawn_valid_i), .spawn_slot_i(spawn_slot_i),
    .spawn_vec_i(spawn_vec_i), .spawn_mask_i(spawn_mask_i),
    .free_valid_i(free_valid_i), .free_slot_i(free_slot_i),
    .abort_o(abort_o)
  );

  task automatic chk(input string tag, input logic [NS-1:0] exp);
    checks++;
    if (abort_o !== exp) begin
      errors++;
      $display("FAIL %s: abort_o=%h expected %h", tag, abort_o, exp);
    end
  endtask

  task automatic set_push(input logic [3:0] a, input logic c);
    br_valid_i = 1'b1; br_addr_i = a; br_conf_i = c;
  endtask
  task automatic set_spawn(input logic [3:0] s, input logic [31:0] v, input logic [7:0] m);
    spawn_valid_i = 1'b1; spawn_slot_i = s; spawn_vec_i = v; spawn_mask_i = m;
  endtask
  task automatic set_rec(input logic [3:0] n);
    rec_valid_i = 1'b1; rec_count_i = n;
  endtask
  task automatic set_free(input logic [3:0] s);
    free_valid_i = 1'b1; free_slot_i = s;
  endtask
  task automatic step();
    @(negedge clk_i);
    br_valid_i = 1'b0; rec_valid_i = 1'b0; spawn_valid_i = 1'b0; free_valid_i = 1'b0;
  endtask
  task automatic push(input logic [3:0] a, input logic c);
    set_push(a, c); step();
  endtask

  task automatic t_reset();
    chk("R1 after reset", '0);
    push(4'h1, 1'b1);
    push(4'h2, 1'b1);
    chk("R1 no entry active", '0);
  endtask

  task automatic t_match();
    set_spawn(4'd2, 32'h753, 8'b111); step();
    push(4'h3, 1'b1); chk("R3 match e0", '0);
    push(4'h5, 1'b1); chk("R3 match e1", '0);
    push(4'h7, 1'b1); chk("R2 match e2", '0);
    push(4'hE, 1'b1); chk("R2 beyond path", '0);
    set_free(4'd2); step();
  endtask

  task automatic t_mismatch();
    set_spawn(4'd5, 32'h753, 8'b111); step();
    push(4'h3, 1'b1);
    push(4'h6, 1'b1); chk("R3 mismatch pulse", 16'h0020);
    step();           chk("R9 pulse ends", '0);
    push(4'h6, 1'b1); chk("R9 retired entry", '0);
  endtask

  task automatic t_mask();
    set_spawn(4'd7, 32'h753, 8'b101); step();
    push(4'h3, 1'b1);
    push(4'h9, 1'b1); chk("R4 masked element", '0);
    push(4'h7, 1'b1); chk("R4 after masked", '0);
    set_free(4'd7); step();
  endtask

  task automatic t_conf();
    set_spawn(4'd1, 32'h753, 8'b111); step();
    push(4'h3, 1'b0);
    push(4'h6, 1'b1); chk("R5 older unconfident", '0);
    set_free(4'd1); step();
    set_spawn(4'd1, 32'h753, 8'b111); step();
    push(4'h3, 1'b1);
    push(4'h6, 1'b0); chk("R5 mismatch unconfident", '0);
    set_free(4'd1); step();
    set_spawn(4'd1, 32'h753, 8'b110); step();
    push(4'h9, 1'b0);
    push(4'h6, 1'b1); chk("R5 unmasked older ignored", 16'h0002);
    step();
  endtask

  task automatic t_spawn_push();
    set_spawn(4'd3, 32'h4, 8'b1); set_push(4'h4, 1'b1); step();
    chk("R2 same-cycle match", '0);
    set_spawn(4'd3, 32'h4, 8'b1); set_push(4'h8, 1'b1); step();
    chk("R2 same-cycle mismatch", 16'h0008);
    step();
  endtask

  task automatic t_recover();
    set_spawn(4'd4, 32'h753, 8'b111); step();
    push(4'h3, 1'b1);
    push(4'h9, 1'b0);
    set_rec(4'd1); step(); chk("R6 recovery quiet", '0);
    push(4'h5, 1'b1);
    push(4'h7, 1'b1); chk("R6 replay matches", '0);
    set_free(4'd4); step();
    set_spawn(4'd4, 32'h753, 8'b111); step();
    push(4'h3, 1'b1);
    push(4'h9, 1'b0);
    set_rec(4'd1); step();
    push(4'h6, 1'b1); chk("R6 replay mismatch", 16'h0010);
    step();
    set_spawn(4'd6, 32'h3, 8'b1); step();
    push(4'h3, 1'b1);
    set_rec(4'd1); step();
    push(4'h8, 1'b1); chk("R6 unwind past spawn", 16'h0040);
    step();
  endtask

  task automatic t_rec_push();
    set_spawn(4'd9, 32'h1, 8'b1); set_rec(4'd1); step();
    chk("R7 spawn in recovery", '0);
    push(4'h2, 1'b1); chk("R7 spawn not unwound", 16'h0200);
    step();
    set_spawn(4'd8, 32'h753, 8'b111); step();
    push(4'h3, 1'b1);
    set_rec(4'd1); set_push(4'h2, 1'b1); step();
    chk("R7 branch dropped", '0);
    push(4'h3, 1'b1);
    push(4'h5, 1'b1); chk("R7 realigned", '0);
    push(4'h8, 1'b1); chk("R7 still active", 16'h0100);
    step();
  endtask

  task automatic t_free();
    set_spawn(4'd10, 32'h3, 8'b1); step();
    set_free(4'd10); step();
    push(4'h4, 1'b1); chk("R8 freed slot", '0);
  endtask

  task automatic t_multi();
    set_spawn(4'd0, 32'h53, 8'b11); step();
    set_spawn(4'd15, 32'h63, 8'b11); step();
    set_spawn(4'd11, 32'h3, 8'b1); step();
    push(4'h3, 1'b1); chk("R10 all match", '0);
    push(4'h5, 1'b1); chk("R10 one slot aborts", 16'h8000);
    step();           chk("R10 others untouched", '0);
    set_free(4'd0); step();
    set_free(4'd11); step();
    set_spawn(4'd12, 32'h1, 8'b1); step();
    set_spawn(4'd13, 32'h1, 8'b1); step();
    push(4'h2, 1'b1); chk("R10 simultaneous", 16'h3000);
    step();
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_match();
    t_mismatch();
    t_mask();
    t_conf();
    t_spawn_push();
    t_recover();
    t_rec_push();
    t_free();
    t_multi();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule